// File: doc/BRIEF.md
# OTP Parallel Programming Port

This block connects an 8-bit parallel data port to an internal one-time-programmable byte array. A programming-mode input decides what the read/strobe line does. With programming mode on, a rising strobe loads the port value into one of four internal registers. The register is chosen by a four-signal code built from the mode input, an active-low output-enable/multi-byte input and a two-bit latch select. The four registers are a test control register, the low address byte, the high address byte and the data register used for multi-byte programming. With programming mode off, a rising strobe starts a read. The port then turns into an output that carries the addressed byte, the security bits or a signature byte.

A falling edge on the active-low write enable programs the data register into the addressed byte, or into the security bits. This happens only while programming mode is on and the programming supply is flagged present. Programming can only clear bits: erased bits read as 1, and each write stores the AND of the old contents and the data register. The array is a plain synchronous register model. Reset models an erased device.

Top module: `otp_port`

## Requirements
- R1: After reset, port_oe is 0, test_ctrl is 8'h00, every array byte reads 8'hFF and the 3 security bits read 3'b111.
- R2: While mode_pgm is 0, a rising strobe loads no register: test_ctrl, the address and the data register keep their values.
- R3: With mode_pgm at 1, a rising strobe loads port_in into a register chosen by ls and gb_n. ls=00 with gb_n=1 selects the test register. ls=11 with gb_n=0 selects the data register. ls=00 with gb_n=0 and ls=11 with gb_n=1 select nothing.
- R4: ls=01 loads address bits 7:0 from port_in and ls=10 loads address bits 14:8 from port_in[6:0]. gb_n is a don't-care for both, and port_in[7] is ignored for the high byte.
- R5: A rising strobe with mode_pgm at 0 sets port_oe and drives the selected byte on port_out one clock later. port_oe stays set while strobe stays high and mode_pgm stays 0. It clears one clock after either of those stops being true.
- R6: A falling edge of we_n with mode_pgm=1 and vpp_ok=1 stores the old byte ANDed with the data register into the array at the current address.
- R7: With vpp_ok at 0, a we_n falling edge changes neither the array nor the security bits.
- R8: With sec_sel=1 and sig_sel=0, a read returns {5'b11111, security bits}, and programming ANDs data register bits 2:0 into the security bits without touching the array.
- R9: With sig_sel=1, a read returns SIG_LO when address bit 0 is 0 and SIG_HI when it is 1, taking priority over sec_sel. Programming with sig_sel=1 changes nothing.
- R10: An address at or above DEPTH reads 8'hFF, and programming it has no effect.
- R11: port_oe is 0 in any cycle after a clock edge at which mode_pgm was 1.
- R12: Security bits never change from 0 to 1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| port_in | input | 8 | Data port, input side |
| port_out | output | 8 | Data port, output side |
| port_oe | output | 1 | Port drives port_out when 1 |
| mode_pgm | input | 1 | Programming mode |
| gb_n | input | 1 | Output-enable / multi-byte programming, active low |
| ls | input | 2 | Latch select |
| strobe | input | 1 | Read/strobe |
| we_n | input | 1 | Write enable, active low |
| sec_sel | input | 1 | Select security bits |
| sig_sel | input | 1 | Select signature bytes |
| vpp_ok | input | 1 | Programming supply present |
| test_ctrl | output | 8 | Test control register contents |

## Verification
The bench builds the block with DEPTH set to 300, so that the array limit sits inside the second high-address page. That puts address 299 and address 300 one strobe apart. Both sides of the limit are then reachable, and the high byte is exercised with a nonzero value. The signature defaults are kept, and the bench passes them explicitly so that its expected read values are fixed.

// File: rtl/otp_port.sv
module otp_port #(
  parameter int ADDR_W = 15,
  parameter int DEPTH  = 2048,
  parameter int SEC_W  = 3,
  parameter logic [7:0] SIG_LO = 8'h15,
  parameter logic [7:0] SIG_HI = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] port_in,
  output logic [7:0] port_out,
  output logic       port_oe,
  input  logic       mode_pgm,
  input  logic       gb_n,
  input  logic [1:0] ls,
  input  logic       strobe,
  input  logic       we_n,
  input  logic       sec_sel,
  input  logic       sig_sel,
  input  logic       vpp_ok,
  output logic [7:0] test_ctrl
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int HI_W  = ADDR_W - 8;

  logic              strobe_q, we_q;
  logic [7:0]        addr_lo, data_lat, rd_data;
  logic [HI_W-1:0]   addr_hi;
  logic [SEC_W-1:0]  sec;
  logic              rd_act;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        rd_src;

  wire               stb_rise = strobe & ~strobe_q;
  wire               we_fall  = ~we_n & we_q;
  wire               sel_test = mode_pgm &  gb_n & (ls == 2'b00);
  wire               sel_lo   = mode_pgm & (ls == 2'b01);
  wire               sel_hi   = mode_pgm & (ls == 2'b10);
  wire               sel_data = mode_pgm & ~gb_n & (ls == 2'b11);
  wire [ADDR_W-1:0]  addr     = {addr_hi, addr_lo};
  wire               in_range = 32'(addr) < 32'(DEPTH);
  wire [IDX_W-1:0]   idx      = addr[IDX_W-1:0];
  wire               prog_ok  = we_fall & mode_pgm & vpp_ok & ~sig_sel;

  always_comb begin
    if (sig_sel)       rd_src = addr_lo[0] ? SIG_HI : SIG_LO;
    else if (sec_sel)  rd_src = {{(8-SEC_W){1'b1}}, sec};
    else if (in_range) rd_src = mem[idx];
    else               rd_src = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      we_q      <= 1'b1;
      test_ctrl <= '0;
      addr_lo   <= '0;
      addr_hi   <= '0;
      data_lat  <= 8'hFF;
      sec       <= '1;
      rd_act    <= 1'b0;
      rd_data   <= 8'hFF;
    end else begin
      strobe_q <= strobe;
      we_q     <= we_n;
      if (stb_rise) begin
        if (sel_test) test_ctrl <= port_in;
        if (sel_lo)   addr_lo   <= port_in;
        if (sel_hi)   addr_hi   <= port_in[HI_W-1:0];
        if (sel_data) data_lat  <= port_in;
      end
      if (prog_ok && sec_sel) sec <= sec & data_lat[SEC_W-1:0];
      rd_act <= ~mode_pgm & strobe & (stb_rise | rd_act);
      if (stb_rise && !mode_pgm) rd_data <= rd_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_ok && !sec_sel && in_range) begin
      mem[idx] <= mem[idx] & data_lat;
    end
  end

  assign port_oe  = rd_act;
  assign port_out = rd_data;
endmodule

// File: rtl/otp_port_chk.sv
module otp_port_chk #(
  parameter int SEC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_pgm,
  input logic             strobe,
  input logic             port_oe,
  input logic             vpp_ok,
  input logic [7:0]       test_ctrl,
  input logic [SEC_W-1:0] sec
);
  // R11
  oe_off_in_pgm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_pgm |=> !port_oe);

  // R2
  test_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_pgm |=> $stable(test_ctrl));

  // R5
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_oe) |-> $past(strobe && !mode_pgm));

  // R7
  sec_no_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_ok |=> $stable(sec));

  // R12
  sec_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sec & ~$past(sec)) == '0));
endmodule

bind otp_port otp_port_chk #(.SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_pgm(mode_pgm), .strobe(strobe),
  .port_oe(port_oe), .vpp_ok(vpp_ok), .test_ctrl(test_ctrl), .sec(sec)
);

// File: tb/otp_port_tb.sv
module otp_port_tb;
  logic       clk = 0, rst_n = 0;
  logic [7:0] port_in = 0, port_out, test_ctrl;
  logic       port_oe, mode_pgm = 0, gb_n = 1, strobe = 0, we_n = 1;
  logic       sec_sel = 0, sig_sel = 0, vpp_ok = 1;
  logic [1:0] ls = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  otp_port #(.ADDR_W(15), .DEPTH(300), .SEC_W(3), .SIG_LO(8'h15), .SIG_HI(8'h07)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
    .mode_pgm(mode_pgm), .gb_n(gb_n), .ls(ls), .strobe(strobe), .we_n(we_n),
    .sec_sel(sec_sel), .sig_sel(sig_sel), .vpp_ok(vpp_ok), .test_ctrl(test_ctrl));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(logic g, logic [1:0] l, logic [7:0] d);
    @(negedge clk); mode_pgm = 1; gb_n = g; ls = l; port_in = d; strobe = 1;
    @(negedge clk); strobe = 0;
    @(negedge clk);
  endtask

  task automatic set_addr(logic [14:0] a);
    load(1'b0, 2'b01, a[7:0]);
    load(1'b1, 2'b10, {1'b0, a[14:8]});
  endtask

  task automatic prog(logic [7:0] d);
    load(1'b0, 2'b11, d);
    @(negedge clk); mode_pgm = 1; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(string req, logic [7:0] exp);
    @(negedge clk); mode_pgm = 0; strobe = 1;
    @(negedge clk); chk({req, " oe"}, {7'b0, port_oe}, 8'h01); chk(req, port_out, exp);
    strobe = 0;
    @(negedge clk); chk({req, " oe off"}, {7'b0, port_oe}, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 oe", {7'b0, port_oe}, 8'h00);
    chk("R1 test", test_ctrl, 8'h00);
    set_addr(15'd5); rd("R1 erased", 8'hFF);
    sec_sel = 1; rd("R1 sec", 8'hFF); sec_sel = 0;
  endtask

  task automatic t_decode;
    load(1'b1, 2'b00, 8'hA5); chk("R3 test load", test_ctrl, 8'hA5);
    load(1'b0, 2'b00, 8'h3C); chk("R3 gb0 ls00 none", test_ctrl, 8'hA5);
    @(negedge clk); mode_pgm = 0; gb_n = 1; ls = 0; port_in = 8'h77; strobe = 1;
    @(negedge clk); strobe = 0;
    @(negedge clk); chk("R2 no load", test_ctrl, 8'hA5);
  endtask

  task automatic t_program;
    load(1'b0, 2'b01, 8'h05); load(1'b1, 2'b10, 8'h80);
    prog(8'hF0); rd("R4 R6 first", 8'hF0);
    prog(8'h3C); rd("R6 and", 8'h30);
    set_addr(15'd6);
    load(1'b1, 2'b11, 8'h00);
    @(negedge clk); we_n = 0; @(negedge clk); we_n = 1; @(negedge clk);
    rd("R3 gb1 ls11 none", 8'h3C);
    set_addr(15'd5); rd("R4 R2 addr kept", 8'h30);
  endtask

  task automatic t_vpp;
    set_addr(15'd7); vpp_ok = 0; prog(8'h00); rd("R7 array", 8'hFF);
    sec_sel = 1; prog(8'h00); rd("R7 sec", 8'hFF); sec_sel = 0; vpp_ok = 1;
  endtask

  task automatic t_range;
    set_addr(15'd300); prog(8'h00); rd("R10 high", 8'hFF);
    set_addr(15'd299); prog(8'h5A); rd("R10 last", 8'h5A);
    set_addr(15'd44);  rd("R10 no alias", 8'hFF);
  endtask

  task automatic t_sec_sig;
    set_addr(15'd8); sec_sel = 1; prog(8'hFA); rd("R8 sec", 8'hFA);
    sec_sel = 0; rd("R8 array kept", 8'hFF);
    sig_sel = 1; set_addr(15'd8); rd("R9 sig lo", 8'h15);
    set_addr(15'd9); sec_sel = 1; rd("R9 sig hi prio", 8'h07);
    prog(8'h00); sig_sel = 0; rd("R9 no sec prog", 8'hFA);
    sec_sel = 0; rd("R9 no array prog", 8'hFF);
  endtask

  task automatic t_oe;
    @(negedge clk); mode_pgm = 0; strobe = 1;
    @(negedge clk); @(negedge clk); chk("R5 held", {7'b0, port_oe}, 8'h01);
    mode_pgm = 1;
    @(negedge clk); chk("R11 off", {7'b0, port_oe}, 8'h00);
    strobe = 0; mode_pgm = 0;
    @(negedge clk); chk("R5 stays off", {7'b0, port_oe}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_decode(); t_program(); t_vpp(); t_range(); t_sec_sig(); t_oe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule